// File: doc/BRIEF.md
# Two-Region Translation Table Walker

This block turns a 64-bit input address into a physical address by reading a chain of 64-bit descriptors from memory. A start pulse hands it the address, the access type (write or read, privileged or unprivileged) and the setup of two translation regions. Each region has a size field, a top-byte-ignore flag, a disable flag, a flag that turns off hierarchical permission checks, and a table base register. The walker picks a region, works out the level where the walk starts, and then fetches one descriptor per level through a read port that allows one request at a time. It stops at a page or block descriptor and reports the result or a fault code.

The control path is a four-state machine. IDLE waits for `start`. IDLE→DONE is taken when region selection fails. IDLE→ISSUE is taken when a walk begins. ISSUE raises a one-cycle memory request and always moves ISSUE→WAIT. WAIT holds until `mem_rvalid`. On a table descriptor that passes its checks, WAIT→ISSUE fetches the next level. On a leaf, a bad descriptor, a read error or a permission fault, WAIT→DONE ends the walk. DONE pulses `done` for one cycle and returns DONE→IDLE. The granule is a parameter; its default is 4 KiB, which gives 9 index bits per level and a 48-bit physical address.

Top module: `desc_walker`

## Requirements
- R1: Region 0 is picked when its size field is nonzero and the input-address bits from 63 down to 64−size are all zero. If not, region 1 is tested the same way. Region 0 has priority.
- R2: Bit 55 of the input address chooses the region-1 top-byte-ignore flag (bit 55 = 1) or the region-0 flag (bit 55 = 0). When the chosen flag is set, bits 63:56 are left out of the zero test in R1.
- R3: If no region passes R1, a region whose size is 0 takes the address, and region 0 is tried first. If both sizes are nonzero, or the picked region is disabled, the walk ends with fault code 1 (translation) and issues no memory request.
- R4: Start level = 4 − (insize − 4) / 9, where insize = 64 − max(size, 16). A start level above 3 gives fault code 1 with no request. The first table base is base-register bits 47:0 with the low (insize − 9·(4 − level)) bits cleared.
- R5: A descriptor is read from base + 8·idx. idx = (addr >> sh) & 511, and sh = 12 + 9·(3 − level).
- R6: `mem_req` is high for exactly one cycle per descriptor. No new request is made until `mem_rvalid` has returned the previous one.
- R7: A response with `mem_rerr` set ends the walk with fault code 2 (external abort), and `res_fault_addr` holds the descriptor address that failed.
- R8: A descriptor with bit 0 clear is invalid. A descriptor with bits 1:0 = 01 at level 0 or level 3 is reserved. Either one ends the walk with fault code 1.
- R9: A table descriptor (bits 1:0 = 11 at levels 0–2) faults with code 3 when bit 62 is set on a write, or bit 61 is set on an unprivileged access. This check is skipped when the region's hierarchical-check-disable flag is set. Otherwise the walk moves to the next level, with base = descriptor bits 47:12.
- R10: A leaf (page = 11 at level 3, block = 01 at levels 1–2) faults with code 3 when bit 7 (read-only) is set on a write, or bit 6 (unprivileged allowed) is clear on an unprivileged access.
- R11: On success the fault code is 0. The outputs are: output address = descriptor bits 47:sh with the low bits zero; input base = address with bits below sh cleared; mask = 2^sh − 1; permission = {write allowed = !bit 7, read allowed = 1}; and the final level.
- R12: `done` is a one-cycle pulse. Any fault forces the permission to 00. The result outputs hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken in IDLE) |
| in_addr | input | 64 | Address to translate |
| acc_wr | input | 1 | Access is a write |
| acc_unpriv | input | 1 | Access is unprivileged |
| rgn0_size | input | 6 | Region 0 size field |
| rgn0_top_ign | input | 1 | Region 0 top-byte-ignore |
| rgn0_off | input | 1 | Region 0 disabled |
| rgn0_hier_off | input | 1 | Region 0 skips table permission checks |
| rgn0_base | input | 64 | Region 0 table base register |
| rgn1_size | input | 6 | Region 1 size field |
| rgn1_top_ign | input | 1 | Region 1 top-byte-ignore |
| rgn1_off | input | 1 | Region 1 disabled |
| rgn1_hier_off | input | 1 | Region 1 skips table permission checks |
| rgn1_base | input | 64 | Region 1 table base register |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 48 | Descriptor address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Descriptor data |
| mem_rerr | input | 1 | Read response error |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| res_fault | output | 2 | 0 none, 1 translation, 2 external abort, 3 permission |
| res_out_addr | output | 48 | Translated output address |
| res_in_base | output | 64 | Input address aligned to the level size |
| res_mask | output | 64 | Level size minus one |
| res_perm | output | 2 | {write allowed, read allowed} |
| res_level | output | 2 | Level where the walk ended |
| res_fault_addr | output | 48 | Descriptor address of an external abort |

## Verification
The assertions check on every cycle that a request lasts one cycle, that `done` is a single pulse, that a fault never carries a permission, that a successful result has its input base and output address aligned to its mask, and that results do not change while the block is idle. Only the bench scenarios can show the choices themselves. These are which region the size and top-byte rules pick, the start level and cleared base bits, the descriptor address at each level, the meaning of every descriptor encoding and permission bit, and how the walk behaves when responses are slow or fail.

// File: rtl/walk_pkg.sv
package walk_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_TRANS = 2'd1,
        FLT_ABORT = 2'd2,
        FLT_PERM  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        DK_BAD   = 2'd0,
        DK_TABLE = 2'd1,
        DK_LEAF  = 2'd2
    } dkind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } wstate_e;
endpackage

// File: rtl/walk_region_sel.sv
module walk_region_sel (
    input  logic [63:0] addr,
    input  logic [5:0]  size0,
    input  logic [5:0]  size1,
    input  logic        ign0,
    input  logic        ign1,
    output logic        hit,
    output logic        sel
);
    logic in0, in1;
    int   top;

    always_comb begin
        // bit 55 decides which ignore flag governs the top byte
        top = (addr[55] ? ign1 : ign0) ? 56 : 64;
        in0 = (size0 != 6'd0);
        in1 = (size1 != 6'd0);
        for (int i = 0; i < 64; i++) begin
            if (i >= 64 - int'(size0) && i < top && addr[i]) in0 = 1'b0;
            if (i >= 64 - int'(size1) && i < top && addr[i]) in1 = 1'b0;
        end
        hit = 1'b1;
        sel = 1'b0;
        if (in0)                 sel = 1'b0;
        else if (in1)            sel = 1'b1;
        else if (size0 == 6'd0)  sel = 1'b0;
        else if (size1 == 6'd0)  sel = 1'b1;
        else                     hit = 1'b0;
    end
endmodule

// File: rtl/walk_desc_dec.sv
module walk_desc_dec #(
    parameter int GRAN = 12,
    parameter int PA_W = 48
) (
    input  logic [63:0]     desc,
    input  logic [2:0]      level,
    input  logic            acc_wr,
    input  logic            acc_unpriv,
    input  logic            hier_off,
    output walk_pkg::dkind_e kind,
    output logic            perm_fail,
    output logic [5:0]      lvl_shift,
    output logic [63:0]     lvl_mask,
    output logic [PA_W-1:0] next_addr
);
    import walk_pkg::*;
    localparam int STRIDE = GRAN - 3;
    localparam logic [PA_W-1:0] GRAN_MASK = PA_W'((64'd1 << GRAN) - 64'd1);

    logic unused_desc;
    assign unused_desc = ^{desc[63], desc[60:PA_W]};

    assign lvl_shift = 6'(GRAN + (3 - int'(level)) * STRIDE);
    assign lvl_mask  = (64'd1 << lvl_shift) - 64'd1;

    always_comb begin
        kind      = DK_BAD;
        perm_fail = 1'b0;
        next_addr = desc[PA_W-1:0] & ~lvl_mask[PA_W-1:0];
        if (desc[0]) begin
            if (desc[1]) begin
                if (level == 3'd3) begin
                    kind = DK_LEAF;
                end else begin
                    kind      = DK_TABLE;
                    next_addr = desc[PA_W-1:0] & ~GRAN_MASK;
                end
            end else if (level != 3'd0 && level != 3'd3) begin
                kind = DK_LEAF;
            end
        end
        if (kind == DK_TABLE)
            perm_fail = ((acc_wr & desc[62]) | (acc_unpriv & desc[61])) & ~hier_off;
        else if (kind == DK_LEAF)
            perm_fail = (acc_wr & desc[7]) | (acc_unpriv & ~desc[6]);
    end
endmodule

// File: rtl/desc_walker.sv
module desc_walker #(
    parameter int GRAN = 12,
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [63:0]     in_addr,
    input  logic            acc_wr,
    input  logic            acc_unpriv,
    input  logic [5:0]      rgn0_size,
    input  logic            rgn0_top_ign,
    input  logic            rgn0_off,
    input  logic            rgn0_hier_off,
    input  logic [63:0]     rgn0_base,
    input  logic [5:0]      rgn1_size,
    input  logic            rgn1_top_ign,
    input  logic            rgn1_off,
    input  logic            rgn1_hier_off,
    input  logic [63:0]     rgn1_base,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [63:0]     mem_rdata,
    input  logic            mem_rerr,
    output logic            busy,
    output logic            done,
    output logic [1:0]      res_fault,
    output logic [PA_W-1:0] res_out_addr,
    output logic [63:0]     res_in_base,
    output logic [63:0]     res_mask,
    output logic [1:0]      res_perm,
    output logic [1:0]      res_level,
    output logic [PA_W-1:0] res_fault_addr
);
    import walk_pkg::*;
    localparam int STRIDE  = GRAN - 3;
    localparam int MAX_IN  = GRAN + 4 * STRIDE;
    localparam int MIN_SZ  = 64 - MAX_IN;
    localparam logic [63:0] IDX_MASK = (64'd1 << STRIDE) - 64'd1;

    wstate_e         state;
    logic [63:0]     addr_q;
    logic [PA_W-1:0] base_q;
    logic [2:0]      lvl_q;
    logic            wr_q, unp_q, hier_q;

    // region choice
    logic        sel_hit, sel;
    logic [5:0]  sel_size;
    logic [63:0] sel_base;
    logic        sel_off, sel_hier;

    walk_region_sel u_sel (
        .addr(in_addr), .size0(rgn0_size), .size1(rgn1_size),
        .ign0(rgn0_top_ign), .ign1(rgn1_top_ign), .hit(sel_hit), .sel(sel)
    );

    assign sel_size = sel ? rgn1_size : rgn0_size;
    assign sel_base = sel ? rgn1_base : rgn0_base;
    assign sel_off  = sel ? rgn1_off  : rgn0_off;
    assign sel_hier = sel ? rgn1_hier_off : rgn0_hier_off;

    logic unused_base;
    assign unused_base = ^sel_base[63:PA_W];

    // start level and first-table base mask
    logic [2:0]      st_lvl;
    logic [PA_W-1:0] st_mask;
    int eff_sz, in_sz, lv, nbits;
    always_comb begin
        eff_sz  = (int'(sel_size) < MIN_SZ) ? MIN_SZ : int'(sel_size);
        in_sz   = 64 - eff_sz;
        lv      = 4 - (in_sz - 4) / STRIDE;
        nbits   = in_sz - STRIDE * (4 - lv);
        st_lvl  = 3'(lv);
        st_mask = (lv <= 3 && nbits > 0) ? PA_W'((64'd1 << nbits) - 64'd1) : '0;
    end

    // descriptor decode
    dkind_e          d_kind;
    logic            d_pfail;
    logic [5:0]      d_shift;
    logic [63:0]     d_mask;
    logic [PA_W-1:0] d_next;

    walk_desc_dec #(.GRAN(GRAN), .PA_W(PA_W)) u_dec (
        .desc(mem_rdata), .level(lvl_q), .acc_wr(wr_q), .acc_unpriv(unp_q),
        .hier_off(hier_q), .kind(d_kind), .perm_fail(d_pfail),
        .lvl_shift(d_shift), .lvl_mask(d_mask), .next_addr(d_next)
    );

    assign mem_addr = base_q + PA_W'(((addr_q >> d_shift) & IDX_MASK) << 3);

    // state and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            addr_q <= '0; base_q <= '0; lvl_q <= '0;
            wr_q <= 1'b0; unp_q <= 1'b0; hier_q <= 1'b0;
            res_fault <= FLT_NONE; res_out_addr <= '0; res_in_base <= '0;
            res_mask <= '0; res_perm <= 2'b00; res_level <= '0; res_fault_addr <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    addr_q <= in_addr;
                    wr_q   <= acc_wr;
                    unp_q  <= acc_unpriv;
                    hier_q <= sel_hier;
                    res_perm <= 2'b00;
                    if (!sel_hit || sel_off || st_lvl > 3'd3) begin
                        res_fault <= FLT_TRANS;
                        state     <= S_DONE;
                    end else begin
                        base_q <= sel_base[PA_W-1:0] & ~st_mask;
                        lvl_q  <= st_lvl;
                        state  <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        res_fault      <= FLT_ABORT;
                        res_fault_addr <= mem_addr;
                        state          <= S_DONE;
                    end else if (d_kind == DK_BAD) begin
                        res_fault <= FLT_TRANS;
                        state     <= S_DONE;
                    end else if (d_pfail) begin
                        res_fault <= FLT_PERM;
                        state     <= S_DONE;
                    end else if (d_kind == DK_TABLE) begin
                        base_q <= d_next;
                        lvl_q  <= lvl_q + 3'd1;
                        state  <= S_ISSUE;
                    end else begin
                        res_fault    <= FLT_NONE;
                        res_out_addr <= d_next;
                        res_in_base  <= addr_q & ~d_mask;
                        res_mask     <= d_mask;
                        res_perm     <= {~mem_rdata[7], 1'b1};
                        res_level    <= lvl_q[1:0];
                        state        <= S_DONE;
                    end
                end
                S_DONE: state <= S_IDLE;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        mem_req = (state == S_ISSUE);
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
    end

    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_fault_noperm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault != FLT_NONE) |-> res_perm == 2'b00);
    p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault == FLT_NONE) |->
            ((res_in_base & res_mask) == 64'd0 && (res_out_addr & res_mask[PA_W-1:0]) == '0));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_fault) && $stable(res_out_addr) && $stable(res_perm)));
endmodule

// File: tb/desc_walker_test.sv
module desc_walker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 0, acc_wr = 0, acc_unpriv = 0;
    logic [63:0] in_addr = '0;
    logic [5:0]  r0_size = 0, r1_size = 0;
    logic        r0_ign = 0, r1_ign = 0, r0_off = 0, r1_off = 0, r0_hier = 0, r1_hier = 0;
    logic [63:0] r0_base = '0, r1_base = '0;
    logic        mem_req, mem_rvalid, mem_rerr, busy, done;
    logic [47:0] mem_addr, res_out_addr, res_fault_addr;
    logic [63:0] mem_rdata, res_in_base, res_mask;
    logic [1:0]  res_fault, res_perm, res_level;

    desc_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_addr(in_addr),
        .acc_wr(acc_wr), .acc_unpriv(acc_unpriv),
        .rgn0_size(r0_size), .rgn0_top_ign(r0_ign), .rgn0_off(r0_off),
        .rgn0_hier_off(r0_hier), .rgn0_base(r0_base),
        .rgn1_size(r1_size), .rgn1_top_ign(r1_ign), .rgn1_off(r1_off),
        .rgn1_hier_off(r1_hier), .rgn1_base(r1_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .busy(busy), .done(done),
        .res_fault(res_fault), .res_out_addr(res_out_addr), .res_in_base(res_in_base),
        .res_mask(res_mask), .res_perm(res_perm), .res_level(res_level),
        .res_fault_addr(res_fault_addr)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // memory model
    logic [47:0] tab_a [16];
    logic [63:0] tab_d [16];
    int          tab_n = 0;
    logic [47:0] err_addr = '0;
    logic        err_en = 0;
    int          resp_delay = 0;
    logic        clr = 0;
    int          req_cnt, proto_err, wcnt;
    logic [47:0] first_addr, pend_addr;
    logic        pend;

    function automatic logic [63:0] lookup(input logic [47:0] a);
        for (int k = 0; k < 16; k++)
            if (k < tab_n && tab_a[k] == a) return tab_d[k];
        return 64'd0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n || clr) begin
            req_cnt <= 0; proto_err <= 0; pend <= 0; first_addr <= '0;
            mem_rdata <= '0; mem_rerr <= 0; wcnt <= 0; pend_addr <= '0;
        end else if (mem_req) begin
            if (pend) proto_err <= proto_err + 1;
            pend <= 1; pend_addr <= mem_addr; wcnt <= resp_delay;
            req_cnt <= req_cnt + 1;
            if (req_cnt == 0) first_addr <= mem_addr;
        end else if (pend) begin
            if (wcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= lookup(pend_addr);
                mem_rerr   <= err_en && (pend_addr == err_addr);
                pend <= 0;
            end else wcnt <= wcnt - 1;
        end
    end

    task automatic put(input logic [47:0] a, input logic [63:0] d);
        tab_a[tab_n] = a; tab_d[tab_n] = d; tab_n++;
    endtask

    function automatic logic [47:0] d_addr(input logic [47:0] b, input logic [63:0] va, input int lv);
        return b + 48'(((va >> (12 + 9 * (3 - lv))) & 64'd511) << 3);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    localparam logic [47:0] B0 = 48'h10_0000;

    task automatic reset_env();
        @(negedge clk);
        tab_n = 0; err_en = 0; resp_delay = 0; clr = 1;
        r0_size = 16; r0_ign = 0; r0_off = 0; r0_hier = 0; r0_base = {16'h0, B0};
        r1_size = 16; r1_ign = 0; r1_off = 0; r1_hier = 0; r1_base = 64'h0;
        acc_wr = 0; acc_unpriv = 0;
        @(negedge clk); clr = 0;
    endtask

    // four-level chain used by many scenarios
    task automatic chain(input logic [63:0] va, input logic [63:0] leaf, input logic [63:0] l0x);
        put(d_addr(B0, va, 0), 64'h20_0003 | l0x);
        put(d_addr(48'h20_0000, va, 1), 64'h30_0003);
        put(d_addr(48'h30_0000, va, 2), 64'h40_0003);
        put(d_addr(48'h40_0000, va, 3), leaf);
    endtask

    task automatic walk(input logic [63:0] va, input logic wr, input logic unp);
        @(negedge clk);
        in_addr = va; acc_wr = wr; acc_unpriv = unp; start = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            start = 0;
            if (done) return;
        end
        n_chk++; n_bad++;
        $display("FAIL R12 no done actual=0 expected=1");
    endtask

    task automatic exp_ok(input string t, input logic [47:0] o, input logic [63:0] b,
                          input logic [63:0] m, input logic [1:0] p, input logic [1:0] l, input int reqs);
        chk({t, " fault"}, 64'(res_fault), 64'd0);
        chk({t, " out"}, 64'(res_out_addr), 64'(o));
        chk({t, " base"}, res_in_base, b);
        chk({t, " mask"}, res_mask, m);
        chk({t, " perm"}, 64'(res_perm), 64'(p));
        chk({t, " level"}, 64'(res_level), 64'(l));
        chk({t, " reqs"}, 64'(req_cnt), 64'(reqs));
    endtask

    task automatic exp_flt(input string t, input logic [1:0] code, input int reqs);
        chk({t, " fault"}, 64'(res_fault), 64'(code));
        chk({t, " perm none"}, 64'(res_perm), 64'd0);
        chk({t, " reqs"}, 64'(req_cnt), 64'(reqs));
    endtask

    localparam logic [63:0] VA = 64'h0000_0012_3456_7ABC;

    task automatic t_reset();
        chk("R12 reset busy", 64'(busy), 0);
        chk("R12 reset done", 64'(done), 0);
        chk("R6 reset req", 64'(mem_req), 0);
    endtask

    task automatic t_page();  // R1 R5 R11
        reset_env(); chain(VA, 64'hABCD_E043, 0);
        walk(VA, 0, 1);
        exp_ok("R11 page", 48'hABCD_E000, VA & ~64'hFFF, 64'hFFF, 2'b11, 2'd3, 4);
        chk("R5 first addr", 64'(first_addr), 64'(d_addr(B0, VA, 0)));
        chk("R12 hold after done", 64'(res_out_addr), 64'hABCD_E000);
    endtask

    task automatic t_block();  // R4 R11
        logic [63:0] va = 64'h0000_0000_4567_89AB;
        reset_env(); r0_size = 25; r0_base = 64'hFFFF_0000_0080_0123;
        put(d_addr(48'h80_0000, va, 1), 64'h9003);
        put(d_addr(48'h9000, va, 2), 64'h3FE0_1041);
        walk(va, 1, 0);
        exp_ok("R4 block l2", 48'h3FE0_0000, va & ~64'h1F_FFFF, 64'h1F_FFFF, 2'b11, 2'd2, 2);
        chk("R4 start base", 64'(first_addr), 64'(d_addr(48'h80_0000, va, 1)));
    endtask

    task automatic t_rgn1();  // R3 R4
        logic [63:0] va = 64'hFFFF_8000_0000_0000;
        reset_env(); r1_size = 0; r1_base = 64'hA0_0000;
        put(d_addr(48'hA0_0000, va, 0), 64'h5_0003);
        put(d_addr(48'h5_0000, va, 1), 64'h4000_0041);
        walk(va, 0, 0);
        exp_ok("R3 rgn1 fallback", 48'h4000_0000, va & ~64'h3FFF_FFFF, 64'h3FFF_FFFF, 2'b11, 2'd1, 2);
        chk("R3 rgn1 first addr", 64'(first_addr), 64'(48'hA0_0000 + 48'd256 * 8));
    endtask

    task automatic t_tbi();  // R2 R1 R3
        logic [63:0] va = 64'hAB00_0012_3456_7ABC;
        reset_env(); r0_ign = 1; chain(va, 64'hABCD_E043, 0);
        walk(va, 0, 0);
        exp_ok("R2 top ignored", 48'hABCD_E000, va & ~64'hFFF, 64'hFFF, 2'b11, 2'd3, 4);
        reset_env(); r0_ign = 0; r1_ign = 1;
        walk(va, 0, 0);
        exp_flt("R2 bit55 picks rgn0 flag", 2'd1, 0);
        reset_env();
        walk(va, 0, 0);
        exp_flt("R3 gap fault", 2'd1, 0);
    endtask

    task automatic t_off();  // R3 R4
        reset_env(); r0_off = 1; chain(VA, 64'hABCD_E043, 0);
        walk(VA, 0, 0);
        exp_flt("R3 disabled", 2'd1, 0);
        reset_env(); r0_size = 60;
        walk(64'h5, 0, 0);
        exp_flt("R4 level over 3", 2'd1, 0);
    endtask

    task automatic t_bad();  // R8
        reset_env();
        walk(VA, 0, 0);
        exp_flt("R8 invalid", 2'd1, 1);
        reset_env(); chain(VA, 64'hABCD_E041, 0);
        walk(VA, 0, 0);
        exp_flt("R8 reserved l3", 2'd1, 4);
        reset_env(); put(d_addr(B0, VA, 0), 64'h8000_0041);
        walk(VA, 0, 0);
        exp_flt("R8 reserved l0 block", 2'd1, 1);
    endtask

    task automatic t_abort();  // R7
        reset_env(); chain(VA, 64'hABCD_E043, 0);
        err_en = 1; err_addr = d_addr(48'h20_0000, VA, 1);
        walk(VA, 0, 0);
        exp_flt("R7 abort", 2'd2, 2);
        chk("R7 fault addr", 64'(res_fault_addr), 64'(d_addr(48'h20_0000, VA, 1)));
    endtask

    task automatic t_perm();  // R10 R11
        reset_env(); chain(VA, 64'hABCD_E0C3, 0);
        walk(VA, 1, 0);
        exp_flt("R10 write ro", 2'd3, 4);
        walk(VA, 0, 0);
        chk("R11 ro perm", 64'(res_perm), 64'b01);
        reset_env(); chain(VA, 64'hABCD_E003, 0);
        walk(VA, 0, 1);
        exp_flt("R10 unpriv denied", 2'd3, 4);
    endtask

    task automatic t_table_perm();  // R9
        reset_env(); chain(VA, 64'hABCD_E043, 64'h4000_0000_0000_0000);
        walk(VA, 1, 0);
        exp_flt("R9 table write deny", 2'd3, 1);
        reset_env(); r0_hier = 1; chain(VA, 64'hABCD_E043, 64'h4000_0000_0000_0000);
        walk(VA, 1, 0);
        exp_ok("R9 hier off", 48'hABCD_E000, VA & ~64'hFFF, 64'hFFF, 2'b11, 2'd3, 4);
        reset_env(); chain(VA, 64'hABCD_E043, 64'h2000_0000_0000_0000);
        walk(VA, 0, 1);
        exp_flt("R9 table unpriv deny", 2'd3, 1);
    endtask

    task automatic t_slow();  // R6
        reset_env(); resp_delay = 3; chain(VA, 64'hABCD_E043, 0);
        walk(VA, 0, 0);
        exp_ok("R6 slow resp", 48'hABCD_E000, VA & ~64'hFFF, 64'hFFF, 2'b11, 2'd3, 4);
        chk("R6 one outstanding", 64'(proto_err), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_page();
        t_block();
        t_rgn1();
        t_tbi();
        t_off();
        t_bad();
        t_abort();
        t_perm();
        t_table_perm();
        t_slow();
        summary();
    end
endmodule